// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block handles the way a CAN controller leaves the bus-off state. A one-cycle entry pulse from the error logic puts it into bus-off. It then watches the sampled bus bits, which arrive with a strobe, and counts groups of consecutive recessive bits. When enough groups have been seen, it clears its bus-off flag and gives a one-cycle completion pulse.

A configuration input chooses between two restart policies. In automatic mode, counting starts as soon as bus-off is entered. In manual mode, the block stays in bus-off until software gives a start pulse, and only then does counting begin. The run length and the number of groups are parameters. By default they are 11 bits per group and 128 groups. A further parameter selects which logic level counts as recessive.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, `busoff_o` and `recovery_done_o` are both 0.
- R2: When `busoff_enter_i` is high outside bus-off while `auto_restart_i` is 1, `busoff_o` rises on the next cycle and group counting begins at once, starting from zero counts.
- R3: When `busoff_enter_i` is high outside bus-off while `auto_restart_i` is 0, `busoff_o` rises, but no strobed bit is counted until a `sw_start_i` pulse arrives or `auto_restart_i` becomes 1.
- R4: A `sw_start_i` pulse while not in bus-off has no effect, and it does not arm counting for a later bus-off.
- R5: While counting, a strobed recessive bit (`bit_value_i` = 1 with the default polarity) extends the current run. The 11th consecutive recessive bit completes one group and starts a new run.
- R6: A strobed dominant bit (`bit_value_i` = 0) clears the current run. The number of groups already completed is kept.
- R7: The counts change only in cycles where `bit_strobe_i` is high.
- R8: When the group count reaches 128, `recovery_done_o` is high for exactly one cycle. In that same cycle `busoff_o` falls. With only recessive bits strobed on every cycle, this happens 1408 cycles after the entry pulse.
- R9: A `busoff_enter_i` pulse while already in bus-off is ignored. It does not change the time at which recovery completes.
- R10: A `sw_start_i` pulse while already counting has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busoff_enter_i | input | 1 | Pulse: the controller has entered bus-off |
| bit_strobe_i | input | 1 | A sampled bus bit is valid this cycle |
| bit_value_i | input | 1 | Sampled bus bit level |
| auto_restart_i | input | 1 | 1 = recover automatically, 0 = wait for software start |
| sw_start_i | input | 1 | Pulse: software start of recovery |
| busoff_o | output | 1 | Controller is in bus-off |
| recovery_done_o | output | 1 | One-cycle pulse when recovery completes |

## Verification
The hardest situation to reach from the ports is the last group completing while the run counter has been cleared by dominant bits partway through earlier groups. Reaching it needs more than a thousand strobed bits, with dominant bits placed at several run positions, including just before a run would wrap. The bench produces it with long generated bit streams. These streams vary the strobe spacing and the dominant-bit spacing, and a behavioural model follows the block on every cycle. Further streams send start pulses and entry pulses at awkward moments: outside bus-off, during manual waiting, and in the middle of counting.

// File: rtl/can_busoff_recovery_pkg.sv
package can_busoff_recovery_pkg;
   typedef enum logic [1:0] {
      BO_IDLE  = 2'd0,
      BO_WAIT  = 2'd1,
      BO_COUNT = 2'd2
   } bo_state_e;
endpackage

// File: rtl/bo_run_counter.sv
module bo_run_counter #(
   parameter int RUN_LEN = 11,
   localparam int RUN_W = $clog2(RUN_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic step_i,
   input  logic recessive_i,
   output logic wrap_o
);
   logic [RUN_W-1:0] run_q;
   logic             at_end;

   initial begin
      assert (RUN_LEN >= 2) else $error("RUN_LEN must be at least 2");
   end

   assign at_end = (run_q == RUN_W'(RUN_LEN - 1));
   assign wrap_o = step_i && recessive_i && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (clr_i) begin
         run_q <= '0;
      end else if (step_i) begin
         if (!recessive_i || at_end) run_q <= '0;
         else                        run_q <= run_q + 1'b1;
      end
   end

   a_r5_run_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_W'(RUN_LEN - 1));
   a_r6_dominant_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !recessive_i) |=> (run_q == '0));
   a_r7_run_holds_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !clr_i) |=> $stable(run_q));
endmodule

// File: rtl/bo_group_counter.sv
module bo_group_counter #(
   parameter int GROUPS = 128,
   localparam int GRP_W = $clog2(GROUPS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   logic [GRP_W-1:0] grp_q;
   logic             full;

   initial begin
      assert (GROUPS >= 1) else $error("GROUPS must be at least 1");
   end

   assign full   = (grp_q == GRP_W'(GROUPS));
   assign last_o = inc_i && (grp_q == GRP_W'(GROUPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q <= '0;
      end else if (clr_i) begin
         grp_q <= '0;
      end else if (inc_i && !full) begin
         grp_q <= grp_q + 1'b1;
      end
   end

   a_r8_group_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      grp_q <= GRP_W'(GROUPS));
   a_r6_group_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !clr_i) |=> $stable(grp_q));
endmodule

// File: rtl/bo_control.sv
module bo_control
   import can_busoff_recovery_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic auto_i,
   input  logic start_i,
   input  logic last_i,
   output logic clr_o,
   output logic count_en_o,
   output logic busoff_o,
   output logic done_o
);
   bo_state_e state_q;

   assign clr_o      = (state_q == BO_IDLE) && enter_i;
   assign count_en_o = (state_q == BO_COUNT);
   assign busoff_o   = (state_q != BO_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BO_IDLE;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            BO_IDLE: begin
               if (enter_i) state_q <= auto_i ? BO_COUNT : BO_WAIT;
            end
            BO_WAIT: begin
               if (start_i || auto_i) state_q <= BO_COUNT;
            end
            BO_COUNT: begin
               if (last_i) begin
                  state_q <= BO_IDLE;
                  done_o  <= 1'b1;
               end
            end
            default: state_q <= BO_IDLE;
         endcase
      end
   end

   a_r4_idle_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BO_IDLE && !enter_i) |=> (state_q == BO_IDLE));
   a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BO_WAIT && !start_i && !auto_i) |=> (state_q == BO_WAIT));
   a_r9_reentry_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BO_COUNT && !last_i) |=> (state_q == BO_COUNT));
endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery #(
   parameter int   RUN_LEN       = 11,
   parameter int   GROUPS        = 128,
   parameter logic RECESSIVE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busoff_enter_i,
   input  logic bit_strobe_i,
   input  logic bit_value_i,
   input  logic auto_restart_i,
   input  logic sw_start_i,
   output logic busoff_o,
   output logic recovery_done_o
);
   logic clr, count_en, step, recessive, wrap, last;

   generate
      if (RECESSIVE_LVL) begin : g_rec_high
         assign recessive = bit_value_i;
      end else begin : g_rec_low
         assign recessive = !bit_value_i;
      end
   endgenerate

   assign step = count_en && bit_strobe_i;

   bo_control u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .enter_i    (busoff_enter_i),
      .auto_i     (auto_restart_i),
      .start_i    (sw_start_i),
      .last_i     (last),
      .clr_o      (clr),
      .count_en_o (count_en),
      .busoff_o   (busoff_o),
      .done_o     (recovery_done_o)
   );

   bo_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (clr),
      .step_i      (step),
      .recessive_i (recessive),
      .wrap_o      (wrap)
   );

   bo_group_counter #(.GROUPS(GROUPS)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .inc_i  (wrap),
      .last_o (last)
   );

   a_r8_done_with_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
      recovery_done_o |-> !busoff_o);
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      recovery_done_o |=> !recovery_done_o);
   a_r8_done_after_busoff: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recovery_done_o) |-> $past(busoff_o));
   a_r2_enter_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!busoff_o && busoff_enter_i) |=> busoff_o);
endmodule

// File: tb/can_busoff_recovery_bench.sv
module can_busoff_recovery_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enter = 1'b0, strobe = 1'b0, bitv = 1'b1, auto_r = 1'b0, start = 1'b0;
   logic busoff, done;

   int checks = 0, fails = 0;
   string cur_req = "R1";

   int m_st = 0;
   int m_run = 0, m_grp = 0;
   int m_done = 0;

   always #5 clk = ~clk;

   can_busoff_recovery u_can_busoff_recovery (
      .clk(clk), .rst_n(rst_n), .busoff_enter_i(enter), .bit_strobe_i(strobe),
      .bit_value_i(bitv), .auto_restart_i(auto_r), .sw_start_i(start),
      .busoff_o(busoff), .recovery_done_o(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one cycle: inputs applied at negedge, model steps at posedge, compare at next negedge
   task automatic tick(input logic e, input logic s, input logic b, input logic st);
      enter = e; strobe = s; bitv = b; start = st;
      @(posedge clk);
      m_done = 0;
      case (m_st)
         0: if (e) begin m_st = auto_r ? 2 : 1; m_run = 0; m_grp = 0; end
         1: if (st || auto_r) m_st = 2;
         default: if (s) begin
            if (!b) m_run = 0;
            else if (m_run == 10) begin
               m_run = 0; m_grp++;
               if (m_grp == 128) begin m_st = 0; m_done = 1; end
            end else m_run++;
         end
      endcase
      @(negedge clk);
      check(busoff == (m_st != 0), cur_req, busoff, m_st != 0);
      check(done == m_done[0], cur_req, done, m_done);
   endtask

   // n cycles; strobe every sp cycles, every dp-th strobe dominant (dp=0: none)
   task automatic stream(input int n, input int sp, input int dp);
      int sc = 0;
      for (int i = 0; i < n; i++) begin
         logic s, b;
         s = ((i % sp) == 0);
         b = 1'b1;
         if (s) begin sc++; if (dp != 0 && (sc % dp) == 0) b = 1'b0; end
         tick(1'b0, s, b, 1'b0);
      end
   endtask

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      check(busoff == 1'b0, "R1", busoff, 0);
      check(done == 1'b0, "R1", done, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R8: auto mode, latency with all-recessive strobes
      cur_req = "R2"; auto_r = 1'b1;
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      check(busoff == 1'b1, "R2", busoff, 1);
      cur_req = "R8"; lat = 0;
      for (int i = 0; i < 2000 && !done; i++) begin
         tick(1'b0, 1'b1, 1'b1, 1'b0); lat++;
      end
      check(lat == 1408, "R8", lat, 1408);
      check(busoff == 1'b0, "R8", busoff, 0);
      tick(1'b0, 1'b0, 1'b1, 1'b0);
      check(done == 1'b0, "R8", done, 0);

      // R5 / R6: dominant bits at several run positions
      cur_req = "R6";
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      stream(2500, 1, 11);
      stream(2500, 1, 13);
      stream(200, 1, 0);
      check(busoff == 1'b0, "R6", busoff, 0);

      // R7: sparse strobes
      cur_req = "R7";
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      stream(300, 3, 0);
      check(busoff == 1'b1, "R7", busoff, 1);
      stream(4500, 3, 0);
      check(busoff == 1'b0, "R7", busoff, 0);

      // R4: start outside bus-off ignored, no pre-arming
      cur_req = "R4"; auto_r = 1'b0;
      tick(1'b0, 1'b1, 1'b1, 1'b1);
      check(busoff == 1'b0, "R4", busoff, 0);
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      // R3: manual wait, strobes ignored
      cur_req = "R3";
      stream(2000, 1, 0);
      check(busoff == 1'b1, "R3", busoff, 1);
      tick(1'b0, 1'b0, 1'b1, 1'b1);
      // R10: start and R9: entry while counting, ignored
      cur_req = "R10";
      stream(500, 1, 0);
      tick(1'b0, 1'b1, 1'b1, 1'b1);
      cur_req = "R9";
      tick(1'b1, 1'b1, 1'b1, 1'b0);
      stream(1000, 1, 0);
      check(busoff == 1'b0, "R9", busoff, 0);

      // R3: auto bit rising during wait starts counting
      cur_req = "R3";
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      stream(50, 1, 0);
      auto_r = 1'b1;
      stream(1500, 2, 7);
      stream(3000, 1, 0);
      check(busoff == 1'b0, "R3", busoff, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule